// File: doc/BRIEF.md
# Load/Store Ordering Buffer

This block keeps every in-flight load and store of an out-of-order core in program order. It lets the core run loads before the addresses of older stores are known. Entries are allocated at issue, in order, through a valid/ready port, and the address of an entry may arrive much later. One entry can resolve its address per cycle. The block answers that event in one of two ways, depending on the kind of entry.

A resolving store scans the younger loads that have already resolved. If one of them has the same address, it read stale memory. The block then reports the oldest such load for flush, and drops that load and everything younger. A resolving load scans the older stores whose addresses are known and picks the closest matching one. From it the load takes the data if the data is present, or the tag of the producer that will supply the data. With no match, the load may access memory. Entries leave from the head in order through a valid/ready retire port.

Back-pressure rules: an allocation is taken only in a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` is low when the buffer is full and in any cycle in which a store resolution detects a violation. A retirement happens only in a cycle where `ret_valid` and `ret_ready` are both high. While `ret_ready` stays low, the head entry and its outputs are held.

Top module: `ldst_order_buf`

## Requirements
- R1: An accepted allocation is written at index `alloc_idx`, which is one past the youngest live entry, modulo DEPTH. With DEPTH live entries, `alloc_ready` is low and no allocation is taken.
- R2: When a store resolves its address, the block checks the younger loads that have already resolved. If any has an equal address, `flush_valid` pulses in the next cycle and `flush_idx` names the oldest of them. Otherwise `flush_valid` stays low.
- R3: After a flush, the reported load and all younger entries are gone, and the next allocation is given index `flush_idx`.
- R4: A resolving load considers only older stores whose addresses have already resolved and are equal to its own. It picks the youngest of them.
- R5: If the picked store already holds its data, then in the cycle after the resolution `lk_valid` is high, `lk_kind` is 1 (forward) and `lk_data` is the store data.
- R6: If the picked store does not yet hold its data, `lk_kind` is 2 (wait) and `lk_tag` is the producer tag given when the store was allocated.
- R7: If no store qualifies, `lk_kind` is 0 (go to memory). Older stores that are still unresolved are ignored.
- R8: `ret_valid` is high only when the head entry has resolved its address. `ret_addr` shows that address. Entries retire in allocation order.
- R9: After reset the buffer is empty: `alloc_ready` is high, `alloc_idx` is 0, and `ret_valid`, `lk_valid` and `flush_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Allocation can be taken |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_tag | input | TAG_W | Producer tag of the store data |
| alloc_idx | output | IDX_W | Index the next allocation receives |
| res_valid | input | 1 | Address resolution strobe |
| res_idx | input | IDX_W | Entry being resolved |
| res_addr | input | ADDR_W | Resolved address |
| sd_valid | input | 1 | Store data arrival strobe |
| sd_idx | input | IDX_W | Store entry receiving data |
| sd_data | input | DATA_W | Store data |
| lk_valid | output | 1 | Load lookup result valid |
| lk_idx | output | IDX_W | Load that the result belongs to |
| lk_kind | output | 2 | 0 memory, 1 forward, 2 wait |
| lk_data | output | DATA_W | Forwarded data |
| lk_tag | output | TAG_W | Producer tag to wait on |
| flush_valid | output | 1 | Ordering violation found |
| flush_idx | output | IDX_W | Oldest violating load |
| ret_valid | output | 1 | Head entry can retire |
| ret_ready | input | 1 | Retire accept |
| ret_is_store | output | 1 | Head entry kind |
| ret_addr | output | ADDR_W | Head entry address |
| ret_data | output | DATA_W | Head entry store data |

## Verification
A corrupted head pointer or count shows up at once on `alloc_idx` and `ret_addr`, so the next allocation or retirement gives it away. A wrong resolved flag or a wrong address in an entry stays hidden until some later resolution reads that entry. It then appears one cycle after that resolution, as a wrong `lk_kind` or `lk_data`, or as a missing or misplaced `flush_idx`. For that reason the stimulus mixes matching and non-matching addresses, resolved and unresolved stores, and stores with and without data. The flush case is then followed by a fresh allocation, which shows where the tail was rewound to.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {
    LK_MEM  = 2'd0,
    LK_FWD  = 2'd1,
    LK_WAIT = 2'd2
  } lk_kind_e;
endpackage

// File: rtl/ldst_fwd_search.sv
// Finds the youngest resolved store older than a load with an equal address.
module ldst_fwd_search #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]             head,
  input  logic [IDX_W-1:0]             ld_idx,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DEPTH-1:0]             cand,
  input  logic [DEPTH-1:0][ADDR_W-1:0] addrs,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx
);
  logic [IDX_W-1:0] ld_age;
  assign ld_age = ld_idx - head;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [IDX_W-1:0] slot;
      slot = head + IDX_W'(k);
      if (IDX_W'(k) < ld_age && cand[slot] && addrs[slot] == addr) begin
        hit     = 1'b1;
        hit_idx = slot;
      end
    end
  end
endmodule

// File: rtl/ldst_viol_search.sv
// Finds the oldest resolved load younger than a store with an equal address.
module ldst_viol_search #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]             head,
  input  logic [IDX_W:0]               count,
  input  logic [IDX_W-1:0]             st_idx,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DEPTH-1:0]             cand,
  input  logic [DEPTH-1:0][ADDR_W-1:0] addrs,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx,
  output logic [IDX_W-1:0]             hit_age
);
  logic [IDX_W-1:0] st_age;
  assign st_age = st_idx - head;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    hit_age = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      logic [IDX_W-1:0] slot;
      slot = head + IDX_W'(k);
      if (IDX_W'(k) > st_age && (IDX_W+1)'(k) < count &&
          cand[slot] && addrs[slot] == addr) begin
        hit     = 1'b1;
        hit_idx = slot;
        hit_age = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/ldst_order_buf.sv
module ldst_order_buf
  import ldst_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic              alloc_is_store,
  input  logic [TAG_W-1:0]  alloc_tag,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              res_valid,
  input  logic [IDX_W-1:0]  res_idx,
  input  logic [ADDR_W-1:0] res_addr,
  input  logic              sd_valid,
  input  logic [IDX_W-1:0]  sd_idx,
  input  logic [DATA_W-1:0] sd_data,
  output logic              lk_valid,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [1:0]        lk_kind,
  output logic [DATA_W-1:0] lk_data,
  output logic [TAG_W-1:0]  lk_tag,
  output logic              flush_valid,
  output logic [IDX_W-1:0]  flush_idx,
  output logic              ret_valid,
  input  logic              ret_ready,
  output logic              ret_is_store,
  output logic [ADDR_W-1:0] ret_addr,
  output logic [DATA_W-1:0] ret_data
);
  localparam logic [IDX_W:0] FULL_CNT = (IDX_W+1)'(DEPTH);

  logic [IDX_W-1:0] head;
  logic [IDX_W:0]   count;

  logic [DEPTH-1:0]             e_store, e_res, e_dok;
  logic [DEPTH-1:0][ADDR_W-1:0] e_addr;
  logic [DEPTH-1:0][DATA_W-1:0] e_data;
  logic [DEPTH-1:0][TAG_W-1:0]  e_tag;

  logic             f_hit, v_hit;
  logic [IDX_W-1:0] f_idx, v_idx, v_age;
  logic             st_res, ld_res, viol, alloc_fire, ret_fire;

  assign alloc_idx   = head + count[IDX_W-1:0];
  assign st_res      = res_valid && e_store[res_idx];
  assign ld_res      = res_valid && !e_store[res_idx];
  assign viol        = st_res && v_hit;
  assign alloc_ready = (count != FULL_CNT) && !viol;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign ret_valid   = (count != '0) && e_res[head];
  assign ret_fire    = ret_valid && ret_ready;
  assign ret_is_store = e_store[head];
  assign ret_addr     = e_addr[head];
  assign ret_data     = e_data[head];

  ldst_fwd_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) fwd_i (
    .head(head), .ld_idx(res_idx), .addr(res_addr),
    .cand(e_store & e_res), .addrs(e_addr),
    .hit(f_hit), .hit_idx(f_idx)
  );

  ldst_viol_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) viol_i (
    .head(head), .count(count), .st_idx(res_idx), .addr(res_addr),
    .cand(~e_store & e_res), .addrs(e_addr),
    .hit(v_hit), .hit_idx(v_idx), .hit_age(v_age)
  );

  // Pointer and occupancy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      count <= '0;
    end else begin
      if (ret_fire) head <= head + 1'b1;
      if (viol)
        count <= {1'b0, v_age} - (IDX_W+1)'(ret_fire);
      else
        count <= count + (IDX_W+1)'(alloc_fire) - (IDX_W+1)'(ret_fire);
    end
  end

  // Entry storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_store <= '0;
      e_res   <= '0;
      e_dok   <= '0;
      e_addr  <= '0;
      e_data  <= '0;
      e_tag   <= '0;
    end else begin
      if (alloc_fire) begin
        e_store[alloc_idx] <= alloc_is_store;
        e_res[alloc_idx]   <= 1'b0;
        e_dok[alloc_idx]   <= 1'b0;
        e_tag[alloc_idx]   <= alloc_tag;
        e_data[alloc_idx]  <= '0;
      end
      if (res_valid) begin
        e_res[res_idx]  <= 1'b1;
        e_addr[res_idx] <= res_addr;
      end
      if (sd_valid) begin
        e_dok[sd_idx]  <= 1'b1;
        e_data[sd_idx] <= sd_data;
      end
    end
  end

  // Registered lookup and flush reports
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_valid    <= 1'b0;
      lk_idx      <= '0;
      lk_kind     <= LK_MEM;
      lk_data     <= '0;
      lk_tag      <= '0;
      flush_valid <= 1'b0;
      flush_idx   <= '0;
    end else begin
      lk_valid    <= ld_res;
      lk_idx      <= res_idx;
      flush_valid <= viol;
      flush_idx   <= v_idx;
      if (!f_hit) begin
        lk_kind <= LK_MEM;
        lk_data <= '0;
        lk_tag  <= '0;
      end else if (e_dok[f_idx]) begin
        lk_kind <= LK_FWD;
        lk_data <= e_data[f_idx];
        lk_tag  <= '0;
      end else begin
        lk_kind <= LK_WAIT;
        lk_data <= '0;
        lk_tag  <= e_tag[f_idx];
      end
    end
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R8
  ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !ret_ready |=> ret_valid && $stable(ret_addr) && $stable(ret_is_store));

  // R2
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> $past(res_valid) && !lk_valid);

  // R5
  lk_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> lk_kind != 2'd3 && !flush_valid);
endmodule

// File: tb/ldst_order_buf_tb_top.sv
module ldst_order_buf_tb_top;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        alloc_valid = 0, alloc_ready, alloc_is_store = 0;
  logic [3:0]  alloc_tag = 0;
  logic [2:0]  alloc_idx;
  logic        res_valid = 0;
  logic [2:0]  res_idx = 0;
  logic [15:0] res_addr = 0;
  logic        sd_valid = 0;
  logic [2:0]  sd_idx = 0;
  logic [15:0] sd_data = 0;
  logic        lk_valid, flush_valid, ret_valid, ret_is_store;
  logic        ret_ready = 0;
  logic [2:0]  lk_idx, flush_idx;
  logic [1:0]  lk_kind;
  logic [15:0] lk_data, ret_addr, ret_data;
  logic [3:0]  lk_tag;

  ldst_order_buf dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_is_store(alloc_is_store), .alloc_tag(alloc_tag), .alloc_idx(alloc_idx),
    .res_valid(res_valid), .res_idx(res_idx), .res_addr(res_addr),
    .sd_valid(sd_valid), .sd_idx(sd_idx), .sd_data(sd_data),
    .lk_valid(lk_valid), .lk_idx(lk_idx), .lk_kind(lk_kind),
    .lk_data(lk_data), .lk_tag(lk_tag),
    .flush_valid(flush_valid), .flush_idx(flush_idx),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_is_store(ret_is_store),
    .ret_addr(ret_addr), .ret_data(ret_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ops: 0 alloc, 1 resolve, 2 store data, 3 retire
  // ek: 0 none, 1 memory, 2 forward, 3 wait, 4 flush at ev, 5 no flush, 6 alloc idx, 7 retire addr
  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  idx;
    logic [15:0] val;
    logic [2:0]  ek;
    logic [15:0] ev;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 4'd1, 16'h0005, 3'd6, 16'd0},
    '{3'd0, 4'd0, 16'h0000, 3'd6, 16'd1},
    '{3'd0, 4'd1, 16'h0006, 3'd6, 16'd2},
    '{3'd0, 4'd0, 16'h0000, 3'd6, 16'd3},
    '{3'd0, 4'd0, 16'h0000, 3'd6, 16'd4},
    '{3'd1, 4'd0, 16'h0100, 3'd5, 16'd0},
    '{3'd2, 4'd0, 16'hAAAA, 3'd0, 16'd0},
    '{3'd1, 4'd1, 16'h0100, 3'd2, 16'hAAAA},
    '{3'd1, 4'd3, 16'h0200, 3'd1, 16'd0},
    '{3'd1, 4'd4, 16'h0100, 3'd2, 16'hAAAA},
    '{3'd1, 4'd2, 16'h0100, 3'd4, 16'd4},
    '{3'd0, 4'd0, 16'h0000, 3'd6, 16'd4},
    '{3'd1, 4'd4, 16'h0100, 3'd3, 16'd6},
    '{3'd2, 4'd2, 16'hBBBB, 3'd0, 16'd0},
    '{3'd0, 4'd0, 16'h0000, 3'd6, 16'd5},
    '{3'd1, 4'd5, 16'h0100, 3'd2, 16'hBBBB},
    '{3'd3, 4'd0, 16'h0000, 3'd7, 16'h0100},
    '{3'd3, 4'd0, 16'h0000, 3'd7, 16'h0100},
    '{3'd3, 4'd0, 16'h0000, 3'd7, 16'h0100},
    '{3'd3, 4'd0, 16'h0000, 3'd7, 16'h0200}
  };

  // Drives one operation just after a rising edge and checks the result after the next edge.
  task automatic step(input vec_t v);
    case (v.op)
      3'd0: begin
        alloc_valid = 1; alloc_is_store = v.idx[0]; alloc_tag = v.val[3:0];
        #1;
        if (v.ek == 3'd6)
          check(alloc_ready && alloc_idx == v.ev[2:0], "R1 R3 alloc index", alloc_idx, v.ev);
      end
      3'd1: begin res_valid = 1; res_idx = v.idx[2:0]; res_addr = v.val; end
      3'd2: begin sd_valid = 1; sd_idx = v.idx[2:0]; sd_data = v.val; end
      default: begin
        ret_ready = 1;
        #1;
        check(ret_valid && ret_addr == v.ev, "R8 retire head", ret_addr, v.ev);
      end
    endcase
    @(posedge clk);
    #1;
    alloc_valid = 0; res_valid = 0; sd_valid = 0; ret_ready = 0;
    case (v.ek)
      3'd1: check(lk_valid && lk_kind == 2'd0, "R7 memory access", lk_kind, 0);
      3'd2: check(lk_valid && lk_kind == 2'd1 && lk_data == v.ev, "R5 forward data", lk_data, v.ev);
      3'd3: check(lk_valid && lk_kind == 2'd2 && lk_tag == v.ev[3:0], "R4 R6 wait tag", lk_tag, v.ev);
      3'd4: check(flush_valid && flush_idx == v.ev[2:0], "R2 flush index", flush_idx, v.ev);
      3'd5: check(!flush_valid, "R2 no flush", flush_valid, 0);
      default: ;
    endcase
  endtask

  task automatic alloc1(input bit st, input int exp_idx);
    step('{3'd0, {3'd0, st}, 16'h0009, 3'd6, 16'(exp_idx)});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    #1;
    // R9 reset state
    check(alloc_ready && alloc_idx == 0, "R9 reset alloc", alloc_idx, 0);
    check(!ret_valid && !lk_valid && !flush_valid, "R9 reset idle",
          {ret_valid, lk_valid, flush_valid}, 0);
    @(posedge clk);
    #1;

    for (int i = 0; i < NV; i++) step(VEC[i]);

    // Directed: fill to full with wraparound (live: 4,5; head 4)
    alloc1(1, 6);
    alloc1(0, 7);
    alloc1(0, 0);
    alloc1(1, 1);
    alloc1(0, 2);
    alloc1(0, 3);
    check(!alloc_ready, "R1 full blocks allocation", alloc_ready, 0);
    // R7: older stores 6 and 1 are unresolved, so they are ignored
    step('{3'd1, 4'd7, 16'h0300, 3'd1, 16'd0});
    step('{3'd1, 4'd0, 16'h0300, 3'd1, 16'd0});
    step('{3'd1, 4'd2, 16'h0300, 3'd1, 16'd0});
    // R2: three younger matching loads, oldest is 7
    step('{3'd1, 4'd6, 16'h0300, 3'd4, 16'd7});
    // R3: tail rewound to the flushed load
    alloc1(0, 7);
    // R8: retire in order, then block on an unresolved head
    step('{3'd3, 4'd0, 16'h0, 3'd7, 16'h0100});
    step('{3'd3, 4'd0, 16'h0, 3'd7, 16'h0100});
    step('{3'd3, 4'd0, 16'h0, 3'd7, 16'h0300});
    check(!ret_valid, "R8 unresolved head held", ret_valid, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule